// File: doc/BRIEF.md
# Two-Level Core Sequencer

This block sequences a small processor core using two cooperating state machines. The outer machine owns execution control. It registers a two-bit command every cycle, coming from input pins or a debug port, and decides whether the core is held in reset, loading its program, paused, single-stepping or running freely. The inner machine owns the instruction phase. It steps each instruction through one to three cycles, depending on whether the instruction reads a constant back out of instruction memory, writes the program counter, or both.

The datapath and memories sit outside this block and follow its strobes:

- A clear strobe while held in reset.
- A load strobe for each program word copied in.
- An execute strobe in the cycle an instruction takes effect.
- A fetch strobe for every extra instruction-memory access.
- A retire pulse on the last cycle of each instruction.

An instruction flagged invalid never executes. Instead, the phase machine parks until the latched command changes.

The latched command, the execution state and the phase code are all visible on the ports every cycle, so a debugger can read them back after each command.

Top module: `core_seq`

## Requirements
- R1: After power-on reset, `cmdLatched` reads 11 (run), `execState` reads 0 (held) and `phase` reads 0 (idle).
- R2: `cmdIn` is registered, and its value appears on `cmdLatched` one clock edge later.
- R3: While `extReset` is high, or the latched command is 00, the execution state becomes 0 at the next edge. In that state `clearStrobe` is high, and the phase returns to 0.
- R4: From state 0, with `extReset` low and a latched command other than 00, the core moves to loading (state 1). In state 1 `loadStrobe` is high. A high `pcOverflow` then moves it to paused (state 2).
- R5: In state 2 with command 11 latched, the core enters running (state 4). The first execute strobe comes two edges after the command is latched.
- R6: In state 2, a change of the latched command to 10 enters stepping (state 3). Exactly one instruction executes and retires, and the core then returns to state 2, even while 10 stays latched.
- R7: If the command in state 4 changes away from 11, the current instruction completes. The core reaches state 2 on the edge after its retire cycle.
- R8: Opcode class 0 (ordinary) without a PC destination, and class 2 (direct PC write) with or without one, each take one INST cycle (phase 1).
- R9: Class 0 with `dstIsPc` high takes INST followed by a program-fetch cycle (phase 3), and `fetchStrobe` is high in that cycle.
- R10: Class 1 (constant load) takes INST then a memory-read cycle (phase 2). With `dstIsPc` high, a phase-3 cycle is added, for three cycles in total.
- R11: Class 3 (invalid) in phase 1 raises no execute strobe and moves the phase to 4 (parked). The phase stays at 4 until the latched command changes. It then returns to 0, and a running or stepping core drops to state 2.
- R12: At most one of the load, clear, fetch and execute strobes is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Power-on reset, active low, asynchronous |
| extReset | input | 1 | External reset request, level sensitive |
| cmdIn | input | 2 | Command: 11 run, 10 step, 01 pause, 00 reset |
| opClass | input | 2 | Decoded opcode class: 0 ordinary, 1 constant load, 2 direct PC write, 3 invalid |
| dstIsPc | input | 1 | Current instruction's destination is the program counter |
| pcOverflow | input | 1 | Program counter wrapped during loading |
| cmdLatched | output | 2 | Registered command |
| execState | output | 3 | Execution state: 0 held, 1 loading, 2 paused, 3 stepping, 4 running |
| phase | output | 3 | Phase: 0 idle, 1 INST, 2 memory read, 3 program fetch, 4 parked |
| loadStrobe | output | 1 | Copy one program word |
| clearStrobe | output | 1 | Clear PC and flags |
| fetchStrobe | output | 1 | Extra instruction-memory access |
| execStrobe | output | 1 | Instruction takes effect |
| instRetire | output | 1 | Last cycle of an instruction |

## Verification
The checks assume that the decoder holds `opClass` and `dstIsPc` steady across every cycle of an instruction, and changes them only on the edge after a retire or while the phase is idle. They also assume `pcOverflow` is raised only while loading. The stimulus changes the opcode class only while the core is paused, or at a sample where the phase is INST after a single-cycle instruction. It pulses the overflow input only in the loading state, so every property sees the same instruction for its whole span.

// File: rtl/coreseq_pkg.sv
package coreseq_pkg;
  localparam int CMD_W   = 2;
  localparam int STATE_W = 3;
  localparam int PHASE_W = 3;
  localparam int OPC_W   = 2;

  typedef enum logic [CMD_W-1:0] {
    CMD_RESET = 2'b00,
    CMD_STOP  = 2'b01,
    CMD_STEP  = 2'b10,
    CMD_START = 2'b11
  } cmd_e;

  typedef enum logic [STATE_W-1:0] {
    EX_HELD = 3'd0,
    EX_LOAD = 3'd1,
    EX_STOP = 3'd2,
    EX_STEP = 3'd3,
    EX_RUN  = 3'd4
  } exec_e;

  typedef enum logic [PHASE_W-1:0] {
    PH_IDLE = 3'd0,
    PH_INST = 3'd1,
    PH_MEMR = 3'd2,
    PH_PCFT = 3'd3,
    PH_PARK = 3'd4
  } phase_e;

  typedef enum logic [OPC_W-1:0] {
    OP_PLAIN  = 2'd0,
    OP_CONST  = 2'd1,
    OP_DIRECT = 2'd2,
    OP_BAD    = 2'd3
  } opc_e;

  // execution control -> phase sequencer
  typedef struct packed {
    logic go;
    logic keepRunning;
    logic abort;
    logic cmdNew;
  } execCtl_t;

  // phase sequencer -> execution control and datapath strobes
  typedef struct packed {
    logic done;
    logic parked;
    logic fetch;
    logic exec;
  } phaseRsp_t;
endpackage

// File: rtl/exec_ctrl.sv
module exec_ctrl
  import coreseq_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             extReset,
  input  logic [CMD_W-1:0] cmdIn,
  input  logic             pcOverflow,
  input  phaseRsp_t        rsp,
  output cmd_e             cmdReg,
  output exec_e            state,
  output execCtl_t         ctl,
  output logic             loadStrobe,
  output logic             clearStrobe
);
  cmd_e  cmdPrev;
  exec_e stateNext;
  logic  abort;
  logic  cmdNew;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdReg  <= CMD_START;
      cmdPrev <= CMD_START;
      state   <= EX_HELD;
    end else begin
      cmdReg  <= cmd_e'(cmdIn);
      cmdPrev <= cmdReg;
      state   <= stateNext;
    end
  end

  always_comb begin
    abort  = extReset || (cmdReg == CMD_RESET);
    cmdNew = (cmdReg != cmdPrev);
    stateNext = state;
    if (abort) begin
      stateNext = EX_HELD;
    end else begin
      unique case (state)
        EX_HELD: stateNext = EX_LOAD;
        EX_LOAD: if (pcOverflow) stateNext = EX_STOP;
        EX_STOP: begin
          if (cmdReg == CMD_START)                stateNext = EX_RUN;
          else if (cmdReg == CMD_STEP && cmdNew)  stateNext = EX_STEP;
        end
        EX_STEP: if (rsp.done || (rsp.parked && cmdNew)) stateNext = EX_STOP;
        EX_RUN: begin
          if ((rsp.done && cmdReg != CMD_START) || (rsp.parked && cmdNew))
            stateNext = EX_STOP;
        end
        default: stateNext = EX_HELD;
      endcase
    end
  end

  always_comb begin
    ctl.go          = (state == EX_RUN) || (state == EX_STEP);
    ctl.keepRunning = (state == EX_RUN) && (cmdReg == CMD_START);
    ctl.abort       = abort;
    ctl.cmdNew      = cmdNew;
    loadStrobe      = (state == EX_LOAD);
    clearStrobe     = (state == EX_HELD);
  end
endmodule

// File: rtl/phase_seq.sv
module phase_seq
  import coreseq_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  execCtl_t         ctl,
  input  logic [OPC_W-1:0] opClass,
  input  logic             dstIsPc,
  output phase_e           phase,
  output phaseRsp_t        rsp
);
  phase_e phaseNext;
  opc_e   op;
  logic   finish;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phase <= PH_IDLE;
    else       phase <= phaseNext;
  end

  always_comb begin
    op        = opc_e'(opClass);
    finish    = 1'b0;
    phaseNext = phase;
    unique case (phase)
      PH_IDLE: if (ctl.go) phaseNext = PH_INST;
      PH_INST: begin
        unique case (op)
          OP_BAD:    phaseNext = PH_PARK;
          OP_CONST:  phaseNext = PH_MEMR;
          OP_PLAIN:  if (dstIsPc) phaseNext = PH_PCFT; else finish = 1'b1;
          default:   finish = 1'b1;
        endcase
      end
      PH_MEMR: if (dstIsPc) phaseNext = PH_PCFT; else finish = 1'b1;
      PH_PCFT: finish = 1'b1;
      PH_PARK: if (ctl.cmdNew) phaseNext = PH_IDLE;
      default: phaseNext = PH_IDLE;
    endcase
    if (finish) phaseNext = ctl.keepRunning ? PH_INST : PH_IDLE;
    if (ctl.abort) phaseNext = PH_IDLE;
  end

  always_comb begin
    rsp.done   = finish;
    rsp.parked = (phase == PH_PARK);
    rsp.fetch  = (phase == PH_MEMR) || (phase == PH_PCFT);
    rsp.exec   = (phase == PH_INST) && (op != OP_BAD);
  end
endmodule

// File: rtl/core_seq.sv
module core_seq
  import coreseq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       extReset,
  input  logic [1:0] cmdIn,
  input  logic [1:0] opClass,
  input  logic       dstIsPc,
  input  logic       pcOverflow,
  output logic [1:0] cmdLatched,
  output logic [2:0] execState,
  output logic [2:0] phase,
  output logic       loadStrobe,
  output logic       clearStrobe,
  output logic       fetchStrobe,
  output logic       execStrobe,
  output logic       instRetire
);
  cmd_e      cmdReg;
  exec_e     exState;
  phase_e    phState;
  execCtl_t  ctl;
  phaseRsp_t rsp;

  exec_ctrl u_exec (
    .clk(clk), .rstN(rstN), .extReset(extReset), .cmdIn(cmdIn),
    .pcOverflow(pcOverflow), .rsp(rsp), .cmdReg(cmdReg), .state(exState),
    .ctl(ctl), .loadStrobe(loadStrobe), .clearStrobe(clearStrobe)
  );

  phase_seq u_phase (
    .clk(clk), .rstN(rstN), .ctl(ctl), .opClass(opClass),
    .dstIsPc(dstIsPc), .phase(phState), .rsp(rsp)
  );

  assign cmdLatched  = cmdReg;
  assign execState   = exState;
  assign phase       = phState;
  assign fetchStrobe = rsp.fetch;
  assign execStrobe  = rsp.exec;
  assign instRetire  = rsp.done;
endmodule

// File: rtl/core_seq_checker.sv
module core_seq_checker (
  input logic       clk,
  input logic       rstN,
  input logic       extReset,
  input logic [1:0] opClass,
  input logic       pcOverflow,
  input logic [1:0] cmdLatched,
  input logic [2:0] execState,
  input logic [2:0] phase,
  input logic       loadStrobe,
  input logic       clearStrobe,
  input logic       fetchStrobe,
  input logic       execStrobe,
  input logic       instRetire
);
  a_r3_ext_reset_holds: assert property (@(posedge clk) disable iff (!rstN)
    extReset |=> (execState == 3'd0));

  a_r4_overflow_pauses: assert property (@(posedge clk) disable iff (!rstN)
    (execState == 3'd1 && pcOverflow && !extReset && cmdLatched != 2'b00)
      |=> (execState == 3'd2));

  a_r5_exec_when_active: assert property (@(posedge clk) disable iff (!rstN)
    execStrobe |-> (execState == 3'd3 || execState == 3'd4));

  a_r6_step_returns: assert property (@(posedge clk) disable iff (!rstN)
    (execState == 3'd3 && instRetire && !extReset && cmdLatched != 2'b00)
      |=> (execState == 3'd2));

  a_r10_memr_after_inst: assert property (@(posedge clk) disable iff (!rstN)
    (phase == 3'd2) |-> ($past(phase) == 3'd1));

  a_r9_pcft_origin: assert property (@(posedge clk) disable iff (!rstN)
    (phase == 3'd3) |-> ($past(phase) == 3'd1 || $past(phase) == 3'd2));

  a_r11_invalid_parks: assert property (@(posedge clk) disable iff (!rstN)
    (phase == 3'd1 && opClass == 2'd3 && !extReset && cmdLatched != 2'b00)
      |=> (phase == 3'd4));

  a_r12_strobes_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({loadStrobe, clearStrobe, fetchStrobe, execStrobe}));
endmodule

bind core_seq core_seq_checker u_chk (
  .clk(clk), .rstN(rstN), .extReset(extReset), .opClass(opClass),
  .pcOverflow(pcOverflow), .cmdLatched(cmdLatched), .execState(execState),
  .phase(phase), .loadStrobe(loadStrobe), .clearStrobe(clearStrobe),
  .fetchStrobe(fetchStrobe), .execStrobe(execStrobe), .instRetire(instRetire)
);

// File: tb/sim_core_seq.sv
module sim_core_seq;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rstN, extReset, dstIsPc, pcOverflow;
  logic [1:0] cmdIn, opClass;
  logic [1:0] cmdLatched;
  logic [2:0] execState, phase;
  logic       loadStrobe, clearStrobe, fetchStrobe, execStrobe, instRetire;

  core_seq u0 (
    .clk(clk), .rstN(rstN), .extReset(extReset), .cmdIn(cmdIn),
    .opClass(opClass), .dstIsPc(dstIsPc), .pcOverflow(pcOverflow),
    .cmdLatched(cmdLatched), .execState(execState), .phase(phase),
    .loadStrobe(loadStrobe), .clearStrobe(clearStrobe),
    .fetchStrobe(fetchStrobe), .execStrobe(execStrobe), .instRetire(instRetire)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  task automatic chkEq(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rstN = 0; extReset = 1; cmdIn = 2'b11; opClass = 0; dstIsPc = 0; pcOverflow = 0;
    repeat (3) @(negedge clk);
    chkEq("R1 cmd after reset", cmdLatched, 3);
    chkEq("R1 state after reset", execState, 0);
    chkEq("R1 phase after reset", phase, 0);
    rstN = 1;
    @(negedge clk);
    chkEq("R3 held by extReset", execState, 0);
    chkEq("R3 clear strobe", clearStrobe, 1);
    cmdIn = 2'b00;
    @(negedge clk);
    extReset = 0;
    repeat (2) @(negedge clk);
    chkEq("R3 held by reset command", execState, 0);
    cmdIn = 2'b01;
    repeat (2) @(negedge clk);
    chkEq("R4 loading", execState, 1);
    chkEq("R4 load strobe", loadStrobe, 1);
    chkEq("R2 cmd latched", cmdLatched, 1);
    repeat (3) @(negedge clk);
    chkEq("R4 loading holds without overflow", execState, 1);
    pcOverflow = 1;
    @(negedge clk);
    pcOverflow = 0;
    chkEq("R4 overflow pauses", execState, 2);

    // step sweep over opcode class and destination
    for (int op = 0; op < 3; op++) begin
      for (int d = 0; d < 2; d++) begin
        int busy, ex, fe, ret, firstEx, multi, expBusy;
        busy = 0; ex = 0; fe = 0; ret = 0; firstEx = 0; multi = 0;
        expBusy = ((op == 1) ? 2 : 1) + ((op != 2 && d == 1) ? 1 : 0);
        opClass = op[1:0]; dstIsPc = d[0]; cmdIn = 2'b10;
        for (int n = 1; n <= 12; n++) begin
          @(negedge clk);
          if (n == 1) chkEq("R2 step latched", cmdLatched, 2);
          if (phase != 0) busy++;
          if (execStrobe) begin ex++; if (firstEx == 0) firstEx = n; end
          fe += fetchStrobe;
          ret += instRetire;
          if ((loadStrobe + clearStrobe + fetchStrobe + execStrobe) > 1) multi++;
        end
        chkEq("R6 single execute", ex, 1);
        chkEq("R6 single retire", ret, 1);
        chkEq("R6 back to pause", execState, 2);
        chkEq("R5 latency to execute", firstEx, 3);
        chkEq("R8/R9/R10 cycles", busy, expBusy);
        chkEq("R9/R10 fetch cycles", fe, expBusy - 1);
        chkEq("R12 exclusive strobes", multi, 0);
        cmdIn = 2'b01;
        repeat (2) @(negedge clk);
      end
    end

    // free running
    begin
      int ret;
      opClass = 0; dstIsPc = 0; cmdIn = 2'b11;
      repeat (3) @(negedge clk);
      chkEq("R5 running", execState, 4);
      chkEq("R5 in INST", phase, 1);
      ret = 0;
      for (int n = 0; n < 10; n++) begin ret += instRetire; @(negedge clk); end
      chkEq("R8 one per cycle", ret, 10);
      opClass = 1; dstIsPc = 1;
      ret = 0;
      for (int n = 0; n < 9; n++) begin #1; ret += instRetire; @(negedge clk); end
      chkEq("R10 three-cycle constant load", ret, 3);
      chkEq("R10 aligned at INST", phase, 1);
      cmdIn = 2'b01;
      @(negedge clk);
      chkEq("R7 still running", execState, 4);
      @(negedge clk);
      chkEq("R7 completes instruction", execState, 4);
      chkEq("R9 pc fetch phase", phase, 3);
      @(negedge clk);
      chkEq("R7 paused after retire", execState, 2);
      chkEq("R7 phase idle", phase, 0);
    end

    // invalid opcode
    opClass = 3; dstIsPc = 0; cmdIn = 2'b11;
    repeat (3) @(negedge clk);
    chkEq("R11 INST with invalid", phase, 1);
    chkEq("R11 no execute", execStrobe, 0);
    for (int n = 0; n < 3; n++) begin
      @(negedge clk);
      chkEq("R11 parked", phase, 4);
      chkEq("R11 parked no execute", execStrobe, 0);
    end
    chkEq("R11 state while parked", execState, 4);
    cmdIn = 2'b01;
    repeat (2) @(negedge clk);
    chkEq("R11 unparked", phase, 0);
    chkEq("R11 paused", execState, 2);

    // external reset while running
    opClass = 0; cmdIn = 2'b11;
    repeat (3) @(negedge clk);
    chkEq("R5 running again", execState, 4);
    extReset = 1;
    @(negedge clk);
    chkEq("R3 reset while running", execState, 0);
    chkEq("R3 phase idle", phase, 0);
    chkEq("R3 clear strobe again", clearStrobe, 1);
    extReset = 0;
    @(negedge clk);
    chkEq("R4 reload after release", execState, 1);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule